// File: doc/BRIEF.md
# Serial Bit-Rate Monitor

This block watches one asynchronous serial line and works out its real bit period in system clock cycles. It makes no assumption about the configured rate. Every transition on the line, rising or falling, closes one interval. The block keeps the shortest interval over a window of intervals as a first estimate of one bit time. In the next window it rounds each interval to a whole number of bits using that estimate. At the end of that window it divides the summed interval lengths by the summed bit counts. The result keeps sub-cycle averaging to the floor of the mean, so odd rates such as ones that are not multiples of 9600 come out as they are.

The measured period is compared with a configured period. A warning is raised when the two differ by more than a set percentage, 3 % by default. The test is done with integer multiplies and one compare, so no divider sits in the compare path. A new configuration, or a line that stays quiet for a configurable number of cycles, restarts the measurement and drops the valid flag and the warning. Each serial line gets its own instance, so the receive and transmit directions are measured independently.

Top module: `baud_monitor`

## Requirements
- R1: After reset, `meas_period` is 0 and both `meas_valid` and `rate_warn` are low.
- R2: Periods are in clock cycles. The reported period is floor(sum of accepted interval lengths / sum of their bit counts) over one window of `WIN` (64) intervals. A line toggling every T cycles reports T.
- R3: Each interval's bit count is round(interval / m), where m is the shortest interval of the previous window. An interval whose count is 0 or above `MAXB` (16) is left out of both sums. With a long idle gap that is not a whole number of bits, the result therefore still equals the bit time.
- R4: After a restart, the first result appears at the end of the second full window, and not before. `meas_valid` then stays high, and the result updates once per window.
- R5: A non-integer mean is truncated. Intervals alternating between 40 and 43 cycles report 41.
- R6: One cycle after each result, `rate_warn` becomes `meas_valid && |meas - cfg| * 100 > TOL_PCT * cfg`. Exactly 3 % off (103 or 97 against 100) gives no warning. 4 % off (104 or 96) warns.
- R7: `rate_warn` is never high while `meas_valid` is low.
- R8: A `cfg_load` pulse latches `cfg_period` and `cfg_timeout` and restarts measurement. One cycle later `meas_valid`, `rate_warn` and `meas_period` are all zero. The first line edge after a restart only starts the interval timer.
- R9: When no edge arrives for `cfg_timeout` cycles (0 disables this), `meas_valid` and `rate_warn` clear and measurement restarts.
- R10: The line passes through a two-stage synchronizer. Rising and falling transitions both delimit intervals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Asynchronous serial line being monitored |
| cfg_load | input | 1 | One-cycle pulse: latch configuration and restart measurement |
| cfg_period | input | CNT_W | Expected bit period in clock cycles |
| cfg_timeout | input | CNT_W | Quiet-line limit in cycles, 0 disables |
| meas_period | output | CNT_W | Measured bit period in clock cycles |
| meas_valid | output | 1 | Measured period is current |
| rate_warn | output | 1 | Measured period is outside tolerance |

## Verification
A wrong minimum or a wrong rounding count does not stay hidden inside the block. It shows up in `meas_period` at the close of the very next window, about 64 bit times later. The bench therefore uses stimuli chosen so that each fault shifts the reported value by at least one cycle: a truncated mean, an idle gap half a bit off a whole count, and periods that sit exactly on and just past the 3 % boundary. A fault in restart or timeout handling shows within one or two cycles on `meas_valid`. A fault in window sequencing shifts the cycle in which the first result appears.

// File: rtl/bm_pkg.sv
package bm_pkg;

  typedef enum logic {RF_IDLE, RF_COUNT} rf_state_e;

  // True when |meas - ref_p| * 100 exceeds pct * ref_p (no division used)
  function automatic logic off_tolerance(input logic [63:0] meas,
                                         input logic [63:0] ref_p,
                                         input logic [63:0] pct);
    logic [63:0] gap;
    gap = (meas > ref_p) ? (meas - ref_p) : (ref_p - meas);
    return (gap * 64'd100) > (ref_p * pct);
  endfunction

endpackage

// File: rtl/bm_edge_timer.sv
module bm_edge_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             line_in,
  input  logic [CNT_W-1:0] timeout,
  output logic             iv_stb,
  output logic [CNT_W-1:0] iv_len,
  output logic             tmo
);

  logic [2:0]       sync_q;
  logic             line_edge;
  logic             armed;
  logic [CNT_W-1:0] cnt;

  // two synchronizer flops plus one history flop for edge detection (R10)
  always_ff @(posedge clk) begin
    if (rst) sync_q <= 3'b111;
    else     sync_q <= {sync_q[1:0], line_in};
  end

  assign line_edge = sync_q[2] ^ sync_q[1];

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      armed  <= 1'b0;
      cnt    <= '0;
      iv_stb <= 1'b0;
      iv_len <= '0;
      tmo    <= 1'b0;
    end else begin
      iv_stb <= 1'b0;
      tmo    <= 1'b0;
      if (line_edge) begin
        armed <= 1'b1;
        cnt   <= CNT_W'(1);
        if (armed) begin          // first edge after restart only arms (R8)
          iv_stb <= 1'b1;
          iv_len <= cnt;
        end
      end else if (armed) begin
        if ((timeout != '0) && (cnt >= timeout)) begin
          tmo   <= 1'b1;          // quiet line (R9)
          armed <= 1'b0;
          cnt   <= '0;
        end else if (cnt != '1) begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  // R2: a reported interval is never empty
  p_interval_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    iv_stb |-> (iv_len != '0));

  // R9: a counter past the limit must disarm on the next edge
  p_timeout_disarms_r9: assert property (@(posedge clk) disable iff (rst || restart)
    (armed && !line_edge && (timeout != '0) && (cnt >= timeout)) |=> (!armed && tmo));

endmodule

// File: rtl/bm_min_window.sv
module bm_min_window #(
  parameter int CNT_W = 32,
  parameter int WIN   = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             iv_stb,
  input  logic [CNT_W-1:0] iv_len,
  output logic [CNT_W-1:0] ref_min,
  output logic             ref_ok,
  output logic             last_iv
);

  localparam int IDX_W = $clog2(WIN);

  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cur_min;
  logic [CNT_W-1:0] lo;

  assign last_iv = (idx == IDX_W'(WIN - 1));
  assign lo      = (iv_len < cur_min) ? iv_len : cur_min;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      idx     <= '0;
      cur_min <= '1;
      ref_min <= '0;
      ref_ok  <= 1'b0;
    end else if (iv_stb) begin
      if (last_iv) begin
        idx     <= '0;
        ref_min <= lo;            // published for use in the next window (R3)
        ref_ok  <= 1'b1;
        cur_min <= '1;
      end else begin
        idx     <= idx + IDX_W'(1);
        cur_min <= lo;
      end
    end
  end

  // R3: the running minimum never exceeds an interval just seen
  p_min_tracks_r3: assert property (@(posedge clk) disable iff (rst || restart)
    (iv_stb && !last_iv) |=> (cur_min <= $past(iv_len)));

  // R3: a published estimate is never zero
  p_ref_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    ref_ok |-> (ref_min != '0));

endmodule

// File: rtl/bm_refine.sv
module bm_refine
  import bm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int MAXB   = 16,
  parameter int SPAN_W = 38,
  parameter int BITS_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              iv_stb,
  input  logic [CNT_W-1:0]  iv_len,
  input  logic [CNT_W-1:0]  ref_min,
  input  logic              ref_ok,
  input  logic              last_iv,
  output logic              div_go,
  output logic [SPAN_W-1:0] div_num,
  output logic [BITS_W-1:0] div_den
);

  localparam int NB_W = $clog2(MAXB + 2);

  rf_state_e         state;
  logic [CNT_W:0]    rem;
  logic [CNT_W-1:0]  step;
  logic [CNT_W-1:0]  cur_iv;
  logic [NB_W-1:0]   n;
  logic              is_last;
  logic [SPAN_W-1:0] span_acc;
  logic [BITS_W-1:0] bits_acc;
  logic              take;
  logic              can_step;
  logic [SPAN_W-1:0] span_nx;
  logic [BITS_W-1:0] bits_nx;

  always_comb begin
    can_step = (rem >= {1'b0, step}) && (n <= NB_W'(MAXB));
    take     = (n != '0) && (n <= NB_W'(MAXB));   // R3 exclusion
    span_nx  = span_acc + (take ? SPAN_W'(cur_iv) : '0);
    bits_nx  = bits_acc + (take ? BITS_W'(n) : '0);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      state    <= RF_IDLE;
      rem      <= '0;
      step     <= '0;
      cur_iv   <= '0;
      n        <= '0;
      is_last  <= 1'b0;
      span_acc <= '0;
      bits_acc <= '0;
      div_go   <= 1'b0;
      div_num  <= '0;
      div_den  <= '0;
    end else begin
      div_go <= 1'b0;
      case (state)
        RF_IDLE: begin
          if (iv_stb && ref_ok) begin
            // rounding by adding half the estimate before counting (R3)
            rem     <= {1'b0, iv_len} + (CNT_W+1)'(ref_min >> 1);
            step    <= ref_min;
            cur_iv  <= iv_len;
            n       <= '0;
            is_last <= last_iv;
            state   <= RF_COUNT;
          end
        end
        RF_COUNT: begin
          if (can_step) begin
            rem <= rem - {1'b0, step};
            n   <= n + NB_W'(1);
          end else begin
            state <= RF_IDLE;
            if (is_last) begin
              span_acc <= '0;
              bits_acc <= '0;
              if (bits_nx != '0) begin
                div_go  <= 1'b1;
                div_num <= span_nx;
                div_den <= bits_nx;
              end
            end else begin
              span_acc <= span_nx;
              bits_acc <= bits_nx;
            end
          end
        end
        default: state <= RF_IDLE;
      endcase
    end
  end

  // R3: the bit counter is bounded one past the accepted maximum
  p_count_bounded_r3: assert property (@(posedge clk) disable iff (rst)
    (state == RF_COUNT) |-> (n <= NB_W'(MAXB + 1)));

  // R2: a division is only requested with a nonzero bit total
  p_go_has_bits_r2: assert property (@(posedge clk) disable iff (rst)
    div_go |-> (div_den != '0));

endmodule

// File: rtl/bm_divider.sv
module bm_divider #(
  parameter int NUM_W = 38,
  parameter int DEN_W = 11,
  parameter int QUO_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [QUO_W-1:0] quo
);

  localparam int K_W = $clog2(NUM_W + 1);

  logic             busy;
  logic [K_W-1:0]   k;
  logic [NUM_W-1:0] shreg;
  logic [DEN_W:0]   rem;
  logic [DEN_W-1:0] dv;
  logic [DEN_W:0]   rem_s;
  logic             ge;

  assign rem_s = {rem[DEN_W-1:0], shreg[NUM_W-1]};
  assign ge    = (rem_s >= {1'b0, dv});
  assign quo   = shreg[QUO_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      k     <= '0;
      shreg <= '0;
      rem   <= '0;
      dv    <= '0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        busy  <= 1'b1;
        k     <= K_W'(NUM_W);
        shreg <= num;
        rem   <= '0;
        dv    <= den;
      end else if (busy) begin
        rem   <= ge ? (rem_s - {1'b0, dv}) : rem_s;
        shreg <= {shreg[NUM_W-2:0], ge};
        k     <= k - K_W'(1);
        if (k == K_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R2: partial remainder stays below the divisor throughout
  p_rem_below_den_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rem < {1'b0, dv}));

  // R2: a new request never lands on a running division
  p_no_go_when_busy_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> !go);

endmodule

// File: rtl/baud_monitor.sv
module baud_monitor
  import bm_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int WIN     = 64,
  parameter int MAXB    = 16,
  parameter int TOL_PCT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_in,
  input  logic             cfg_load,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_timeout,
  output logic [CNT_W-1:0] meas_period,
  output logic             meas_valid,
  output logic             rate_warn
);

  localparam int SPAN_W = CNT_W + $clog2(WIN);
  localparam int BITS_W = $clog2(WIN * MAXB + 1);

  logic [CNT_W-1:0]  cfg_q;
  logic [CNT_W-1:0]  tmo_lim;
  logic              restart;
  logic              tmo;
  logic              iv_stb;
  logic [CNT_W-1:0]  iv_len;
  logic [CNT_W-1:0]  ref_min;
  logic              ref_ok;
  logic              last_iv;
  logic              div_go;
  logic [SPAN_W-1:0] div_num;
  logic [BITS_W-1:0] div_den;
  logic              div_done;
  logic [CNT_W-1:0]  quo;

  assign restart = cfg_load | tmo;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      tmo_lim <= '0;
    end else if (cfg_load) begin
      cfg_q   <= cfg_period;
      tmo_lim <= cfg_timeout;
    end
  end

  bm_edge_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .restart(cfg_load), .line_in(line_in),
    .timeout(tmo_lim), .iv_stb(iv_stb), .iv_len(iv_len), .tmo(tmo)
  );

  bm_min_window #(.CNT_W(CNT_W), .WIN(WIN)) u_minwin (
    .clk(clk), .rst(rst), .restart(restart), .iv_stb(iv_stb),
    .iv_len(iv_len), .ref_min(ref_min), .ref_ok(ref_ok), .last_iv(last_iv)
  );

  bm_refine #(.CNT_W(CNT_W), .MAXB(MAXB), .SPAN_W(SPAN_W), .BITS_W(BITS_W)) u_refine (
    .clk(clk), .rst(rst), .restart(restart), .iv_stb(iv_stb), .iv_len(iv_len),
    .ref_min(ref_min), .ref_ok(ref_ok), .last_iv(last_iv),
    .div_go(div_go), .div_num(div_num), .div_den(div_den)
  );

  bm_divider #(.NUM_W(SPAN_W), .DEN_W(BITS_W), .QUO_W(CNT_W)) u_div (
    .clk(clk), .rst(rst), .restart(restart), .go(div_go),
    .num(div_num), .den(div_den), .done(div_done), .quo(quo)
  );

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      meas_period <= '0;
      meas_valid  <= 1'b0;
      rate_warn   <= 1'b0;
    end else begin
      if (div_done) begin
        meas_period <= quo;
        meas_valid  <= 1'b1;
      end
      rate_warn <= meas_valid &&
                   off_tolerance(64'(meas_period), 64'(cfg_q), 64'(TOL_PCT));
    end
  end

  // R7: no warning without a current measurement
  p_warn_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
    rate_warn |-> meas_valid);

  // R8: reconfiguration clears the result on the next cycle
  p_load_clears_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> (!meas_valid && !rate_warn && (meas_period == '0)));

  // R9: a quiet-line timeout drops the valid flag
  p_timeout_clears_r9: assert property (@(posedge clk) disable iff (rst)
    tmo |=> (!meas_valid && !rate_warn));

  // R4: once valid, the flag holds until a restart
  p_valid_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (meas_valid && !restart) |=> meas_valid);

  // R2: a valid period is never zero
  p_valid_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    meas_valid |-> (meas_period != '0));

endmodule

// File: tb/baud_monitor_bench.sv
module baud_monitor_bench;

  localparam int CNT_W = 32;
  localparam int NVEC  = 7;
  // {half_a, half_b, cfg_period, expected period, expected warn}
  localparam int VEC [NVEC][5] = '{
    '{50,  50,  50,  50,  0},   // R2 R10 plain toggle
    '{40,  43,  41,  41,  0},   // R5 truncated mean
    '{104, 104, 100, 104, 1},   // R6 4 % slow
    '{103, 103, 100, 103, 0},   // R6 exactly 3 %
    '{97,  97,  100, 97,  0},   // R6 exactly 3 % fast
    '{96,  96,  100, 96,  1},   // R6 4 % fast
    '{30,  30,  60,  30,  1}    // R6 far off
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             line_in = 1'b1;
  logic             cfg_load = 1'b0;
  logic [CNT_W-1:0] cfg_period = '0;
  logic [CNT_W-1:0] cfg_timeout = '0;
  logic [CNT_W-1:0] meas_period;
  logic             meas_valid;
  logic             rate_warn;

  int checks = 0;
  int errors = 0;
  int gen_mode = 0;     // 0 hold, 1 toggle, 2 characters
  int half_a = 50;
  int half_b = 50;
  int char_t = 25;
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  baud_monitor u_baud_monitor (
    .clk(clk), .rst(rst), .line_in(line_in), .cfg_load(cfg_load),
    .cfg_period(cfg_period), .cfg_timeout(cfg_timeout),
    .meas_period(meas_period), .meas_valid(meas_valid), .rate_warn(rate_warn)
  );

  // line generator
  initial begin
    forever begin
      if (gen_mode == 1) begin
        repeat (half_a) @(negedge clk);
        line_in = ~line_in;
        repeat (half_b) @(negedge clk);
        line_in = ~line_in;
      end else if (gen_mode == 2) begin
        line_in = 1'b0;                       // start bit
        repeat (char_t) @(negedge clk);
        for (int b = 0; b < 8; b++) begin     // data 0x0F, LSB first
          line_in = (b < 4);
          repeat (char_t) @(negedge clk);
        end
        line_in = 1'b1;                       // stop bit plus idle gap
        repeat (31 * char_t - char_t / 2) @(negedge clk);
      end else begin
        @(negedge clk);
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_cfg(input int per, input int tmo);
    @(negedge clk);
    cfg_period  = per;
    cfg_timeout = tmo;
    cfg_load    = 1'b1;
    @(negedge clk);
    cfg_load    = 1'b0;
  endtask

  task automatic wait_valid(output int cyc);
    cyc = 0;
    while (!meas_valid && cyc < 40000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 period after reset", meas_period, 0);
    chk("R1 valid after reset", meas_valid, 0);
    chk("R1 warn after reset", rate_warn, 0);

    // R4 first result only after two windows (128 intervals of 50 cycles)
    half_a = 50; half_b = 50; gen_mode = 1;
    repeat (300) @(negedge clk);
    load_cfg(50, 5000);
    chk("R8 valid cleared after load", meas_valid, 0);
    wait_valid(cyc);
    chk("R4 first result at second window end", (cyc >= 6350 && cyc <= 6560), 1);
    chk("R2 R10 toggle period", meas_period, 50);

    // stimulus table
    for (int v = 0; v < NVEC; v++) begin
      half_a = VEC[v][0];
      half_b = VEC[v][1];
      repeat (300) @(negedge clk);
      load_cfg(VEC[v][2], 5000);
      chk("R8 load restarts measurement", meas_valid, 0);
      wait_valid(cyc);
      chk("R4 result produced", meas_valid, 1);
      repeat (3) @(negedge clk);
      chk("R2 R5 R10 measured period", meas_period, VEC[v][3]);
      chk("R6 tolerance warning", rate_warn, VEC[v][4]);
      chk("R7 warn implies valid", (!rate_warn || meas_valid), 1);
    end

    // R3 character frames with a gap that rounds to 31 bits (excluded)
    gen_mode = 2; char_t = 25;
    repeat (2000) @(negedge clk);
    load_cfg(25, 5000);
    wait_valid(cyc);
    repeat (3) @(negedge clk);
    chk("R3 framed characters period", meas_period, 25);
    chk("R3 framed characters warn", rate_warn, 0);

    // R9 quiet line timeout, starting from a warning state
    gen_mode = 1; half_a = 104; half_b = 104;
    repeat (300) @(negedge clk);
    load_cfg(100, 5000);
    wait_valid(cyc);
    repeat (3) @(negedge clk);
    chk("R9 warning present before quiet", rate_warn, 1);
    gen_mode = 0;
    repeat (2000) @(negedge clk);
    chk("R9 still valid before timeout", meas_valid, 1);
    repeat (4000) @(negedge clk);
    chk("R9 valid cleared by timeout", meas_valid, 0);
    chk("R9 warning suppressed by timeout", rate_warn, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule